// File: doc/BRIEF.md
# BCD Calendar Clock with Update Cycle

This block keeps the time of day and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It advances by one second for each accepted one-second tick. The count is held internally in plain binary. A separate set of seven host-visible bytes is refreshed from that count during a two-phase update cycle.

The update cycle works as follows. An accepted second tick advances the count and raises the update-in-progress flag. The next delay tick (about 244 µs later in a real system) copies the new time into the visible bytes, in the encoding and hour format currently selected. In that same step the block compares the time with three alarm bytes and raises the alarm and update-ended pulses.

A load strobe writes all seven visible bytes at once. It also sets the internal count from those bytes, decoded in the current encoding. While the set flag is high, the block never overwrites the visible bytes and never starts an update cycle, although the internal count keeps running.

The sequencer has three states:
- `ST_IDLE` goes to `ST_UIP_WAIT` on an accepted tick when the set flag is low.
- `ST_UIP_WAIT` goes to `ST_COMMIT` on a delay tick, or back to `ST_IDLE` when the set flag rises.
- `ST_COMMIT` always returns to `ST_IDLE`.

Top module: `rtc_calendar_core`

## Requirements
- R1: A second tick is accepted only when `osc_ctl` equals 3'b010. With any other code the tick changes nothing: the count does not advance, `uip` stays low, and the visible bytes keep their values.
- R2: With `bin_mode`=0 every visible byte holds two BCD digits (tens in bits 7:4, units in bits 3:0). With `bin_mode`=1 every visible byte holds the plain binary value.
- R3: With `hr24_mode`=1 the hour byte shows 0 to 23. With `hr24_mode`=0 it shows 1 to 12 in bits 6:0, where hours 0 and 12 both show as 12, and bit 7 is set for hours 12 to 23.
- R4: Seconds and minutes wrap from 59 to 0, and the hour wraps from 23 to 0. Day of week counts 0 to 6 and advances when the hour wraps.
- R5: Day of month returns to 1 after the last day of the month. Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days in leap years, where the full year is CENTURY*100+year and follows the rule of divisibility by 4, but not by 100 unless also by 400. Month 12 wraps to 1, and the year then increments modulo 100.
- R6: After reset the visible bytes read sec 0, min 0, hour 0, day of week 0, day of month 1, month 1, year 0, and `uip` is 0. `uip` rises on the clock edge that accepts a tick and stays high until the delay tick. One clock edge after the delay tick, `uip` falls, and on that same edge the visible bytes change and the pulses appear.
- R7: While `set_mode`=1, the visible bytes change only through a load, `uip` is low one edge later, and no update cycle completes. The internal count still advances on accepted ticks. Raising `set_mode` during the update window aborts that cycle without pulses.
- R8: An alarm byte whose bits 7:6 are both 1 matches any value. The other alarm bytes must equal the newly encoded seconds, minutes or hour byte. `alarm_pulse` is high for exactly one cycle at the end of an update cycle when all three match and `alarm_en`=1.
- R9: `upd_done` is high for one cycle at the end of every completed update cycle when `upd_en`=1, and stays low otherwise.
- R10: `load_stb` copies the seven load bytes to the visible bytes on the next edge. It also sets the count from them, decoded in the current encoding. In 12-hour form, bit 7 adds 12 to hours 1 to 11, 12 with bit 7 clear loads as hour 0, and 12 with bit 7 set loads as hour 12. A tick in the same cycle as the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| dly_tick | input | 1 | One-cycle pulse that ends the update window |
| osc_ctl | input | 3 | Divider control; 3'b010 lets time run |
| set_mode | input | 1 | Freeze visible bytes and block update cycles |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| alarm_en | input | 1 | Enable alarm pulse |
| upd_en | input | 1 | Enable update-ended pulse |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| load_stb | input | 1 | Load the seven load bytes |
| ld_sec | input | 8 | Load value, seconds |
| ld_min | input | 8 | Load value, minutes |
| ld_hr | input | 8 | Load value, hour |
| ld_dow | input | 8 | Load value, day of week |
| ld_dom | input | 8 | Load value, day of month |
| ld_mon | input | 8 | Load value, month |
| ld_yr | input | 8 | Load value, year |
| reg_sec | output | 8 | Visible seconds byte |
| reg_min | output | 8 | Visible minutes byte |
| reg_hr | output | 8 | Visible hour byte |
| reg_dow | output | 8 | Visible day-of-week byte |
| reg_dom | output | 8 | Visible day-of-month byte |
| reg_mon | output | 8 | Visible month byte |
| reg_yr | output | 8 | Visible year byte |
| uip | output | 1 | Update in progress |
| alarm_pulse | output | 1 | One-cycle alarm indication |
| upd_done | output | 1 | One-cycle update-ended indication |

## Verification
The hardest states to reach from the ports are the deep rollovers: the last day of each month in leap and non-leap years, the turn of the year at 99, and midnight in 12-hour form. Counting seconds up to them would take far too long. The stimulus therefore loads a time one second before each boundary in every encoding and hour format, then drives a single update cycle and compares the result with a calendar model in the bench. An aborted cycle, where the set flag rises inside the update window, is reached by raising the flag between the two ticks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned N_ALARM = 3;
    localparam logic [2:0]  OSC_RUN = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_UIP_WAIT = 2'd1,
        ST_COMMIT   = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic [BYTE_W-1:0] yr;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] dom;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } cal_regs_t;

    // binary value 0..99 to a visible byte
    function automatic logic [7:0] val_to_reg(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // visible byte to binary value
    function automatic logic [6:0] reg_to_val(input logic [7:0] r, input logic bin);
        return bin ? r[6:0] : (7'(r[7:4]) * 7'd10 + 7'(r[3:0]));
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_cal_pkg::*;
#(
    parameter int unsigned CENTURY = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      load,
    input  cal_time_t load_time,
    output cal_time_t now
);

    localparam logic CENT_LEAP = (CENTURY % 4 == 0);

    cal_time_t  time_q;
    cal_time_t  time_nx;
    logic       leap;
    logic [4:0] mlen;

    always_comb begin
        // year 00 is a century year: leap only when the century is divisible by 4
        leap    = (time_q.yr[1:0] == 2'b00) && ((time_q.yr != 7'd0) || CENT_LEAP);
        mlen    = month_len(time_q.mon, leap);
        time_nx = time_q;
        if (time_q.sec >= 6'd59) begin
            time_nx.sec = 6'd0;
            if (time_q.min >= 6'd59) begin
                time_nx.min = 6'd0;
                if (time_q.hr >= 5'd23) begin
                    time_nx.hr  = 5'd0;
                    time_nx.dow = (time_q.dow >= 3'd6) ? 3'd0 : time_q.dow + 3'd1;
                    if (time_q.dom >= mlen) begin
                        time_nx.dom = 5'd1;
                        if (time_q.mon >= 4'd12) begin
                            time_nx.mon = 4'd1;
                            time_nx.yr  = (time_q.yr >= 7'd99) ? 7'd0 : time_q.yr + 7'd1;
                        end else begin
                            time_nx.mon = time_q.mon + 4'd1;
                        end
                    end else begin
                        time_nx.dom = time_q.dom + 5'd1;
                    end
                end else begin
                    time_nx.hr = time_q.hr + 5'd1;
                end
            end else begin
                time_nx.min = time_q.min + 6'd1;
            end
        end else begin
            time_nx.sec = time_q.sec + 6'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd0,
                        hr: 5'd0, min: 6'd0, sec: 6'd0};
        end else if (load) begin
            time_q <= load_time;
        end else if (step) begin
            time_q <= time_nx;
        end
    end

    assign now = time_q;

endmodule

// File: rtl/rtc_reg_encode.sv
module rtc_reg_encode
    import rtc_cal_pkg::*;
(
    input  cal_time_t t,
    input  logic      bin,
    input  logic      hr24,
    output cal_regs_t r
);

    logic [4:0] h12;
    logic       pm;

    always_comb begin
        pm = (t.hr >= 5'd12);
        if (t.hr == 5'd0) begin
            h12 = 5'd12;
        end else if (pm && (t.hr != 5'd12)) begin
            h12 = t.hr - 5'd12;
        end else begin
            h12 = t.hr;
        end

        r.sec = val_to_reg({1'b0, t.sec}, bin);
        r.min = val_to_reg({1'b0, t.min}, bin);
        r.hr  = hr24 ? val_to_reg({2'b0, t.hr}, bin)
                     : (val_to_reg({2'b0, h12}, bin) | {pm, 7'd0});
        r.dow = val_to_reg({4'b0, t.dow}, bin);
        r.dom = val_to_reg({2'b0, t.dom}, bin);
        r.mon = val_to_reg({3'b0, t.mon}, bin);
        r.yr  = val_to_reg(t.yr, bin);
    end

endmodule

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
    import rtc_cal_pkg::*;
(
    input  cal_regs_t r,
    input  logic      bin,
    input  logic      hr24,
    output cal_time_t t
);

    logic [6:0] hr_v;
    logic [4:0] hr_adj;

    always_comb begin
        hr_v = reg_to_val({1'b0, r.hr[6:0]}, bin);
        if (hr24) begin
            hr_adj = hr_v[4:0];
        end else if (hr_v == 7'd12) begin
            hr_adj = r.hr[7] ? 5'd12 : 5'd0;
        end else begin
            hr_adj = r.hr[7] ? hr_v[4:0] + 5'd12 : hr_v[4:0];
        end

        t.sec = 6'(reg_to_val(r.sec, bin));
        t.min = 6'(reg_to_val(r.min, bin));
        t.hr  = hr_adj;
        t.dow = 3'(reg_to_val(r.dow, bin));
        t.dom = 5'(reg_to_val(r.dom, bin));
        t.mon = 4'(reg_to_val(r.mon, bin));
        t.yr  = reg_to_val(r.yr, bin);
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int unsigned N = 3,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] alm_vec,
    input  logic [N*W-1:0] cur_vec,
    output logic           hit
);

    logic [N-1:0] fld_ok;

    for (genvar i = 0; i < N; i++) begin : g_fld
        assign fld_ok[i] = (alm_vec[i*W + W - 1 -: 2] == 2'b11)
                         || (alm_vec[i*W +: W] == cur_vec[i*W +: W]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned CENTURY  = 20,
    parameter logic [2:0]  RUN_CODE = OSC_RUN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       dly_tick,
    input  logic [2:0] osc_ctl,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       alarm_en,
    input  logic       upd_en,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    input  logic       load_stb,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hr,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_dom,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_yr,
    output logic [7:0] reg_sec,
    output logic [7:0] reg_min,
    output logic [7:0] reg_hr,
    output logic [7:0] reg_dow,
    output logic [7:0] reg_dom,
    output logic [7:0] reg_mon,
    output logic [7:0] reg_yr,
    output logic       uip,
    output logic       alarm_pulse,
    output logic       upd_done
);

    localparam int unsigned AW = N_ALARM * BYTE_W;

    upd_state_e state_q, state_d;
    cal_regs_t  ld_regs, enc_regs, vis_q;
    cal_time_t  ld_time, cur_time;
    logic       tick_ok;
    logic       commit_go;
    logic       alarm_hit;
    logic       uip_q, alarm_q, done_q;
    logic [AW-1:0] alm_vec, cur_vec;

    always_comb begin
        ld_regs.sec = ld_sec;
        ld_regs.min = ld_min;
        ld_regs.hr  = ld_hr;
        ld_regs.dow = ld_dow;
        ld_regs.dom = ld_dom;
        ld_regs.mon = ld_mon;
        ld_regs.yr  = ld_yr;
    end

    // a load in the same cycle wins over the tick
    assign tick_ok   = sec_tick && (osc_ctl == RUN_CODE) && !load_stb;
    assign commit_go = (state_q == ST_COMMIT) && !set_mode && !load_stb;

    rtc_reg_decode u_dec (
        .r    (ld_regs),
        .bin  (bin_mode),
        .hr24 (hr24_mode),
        .t    (ld_time)
    );

    rtc_time_counter #(
        .CENTURY (CENTURY)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (tick_ok),
        .load      (load_stb),
        .load_time (ld_time),
        .now       (cur_time)
    );

    rtc_reg_encode u_enc (
        .t    (cur_time),
        .bin  (bin_mode),
        .hr24 (hr24_mode),
        .r    (enc_regs)
    );

    assign alm_vec = {alm_hr, alm_min, alm_sec};
    assign cur_vec = {enc_regs.hr, enc_regs.min, enc_regs.sec};

    rtc_alarm_match #(
        .N (N_ALARM),
        .W (BYTE_W)
    ) u_alm (
        .alm_vec (alm_vec),
        .cur_vec (cur_vec),
        .hit     (alarm_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_ok && !set_mode) state_d = ST_UIP_WAIT;
            end
            ST_UIP_WAIT: begin
                if (set_mode)      state_d = ST_IDLE;
                else if (dly_tick) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q   <= '{yr: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h00,
                         hr: 8'h00, min: 8'h00, sec: 8'h00};
            uip_q   <= 1'b0;
            alarm_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            uip_q   <= (state_d != ST_IDLE);
            alarm_q <= commit_go && alarm_en && alarm_hit;
            done_q  <= commit_go && upd_en;
            if (load_stb)       vis_q <= ld_regs;
            else if (commit_go) vis_q <= enc_regs;
        end
    end

    assign reg_sec     = vis_q.sec;
    assign reg_min     = vis_q.min;
    assign reg_hr      = vis_q.hr;
    assign reg_dow     = vis_q.dow;
    assign reg_dom     = vis_q.dom;
    assign reg_mon     = vis_q.mon;
    assign reg_yr      = vis_q.yr;
    assign uip         = uip_q;
    assign alarm_pulse = alarm_q;
    assign upd_done    = done_q;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
    parameter logic [2:0] RUN_CODE = 3'b010
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] osc_ctl,
    input logic       set_mode,
    input logic       bin_mode,
    input logic       hr24_mode,
    input logic       alarm_en,
    input logic       upd_en,
    input logic       load_stb,
    input logic [7:0] reg_sec,
    input logic [7:0] reg_min,
    input logic [7:0] reg_hr,
    input logic       uip,
    input logic       alarm_pulse,
    input logic       upd_done
);

    assert_osc_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && (osc_ctl != RUN_CODE)) |=> !uip);

    assert_bcd_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !$past(bin_mode)) |-> ((reg_sec[3:0] < 4'd10) && (reg_min[3:0] < 4'd10)));

    assert_hour_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !$past(hr24_mode)) |-> (reg_hr[6:0] != 7'd0));

    assert_uip_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $fell(uip));

    assert_set_blocks_uip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !uip);

    assert_set_holds_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_mode) && !$past(load_stb)) |->
            ($stable(reg_sec) && $stable(reg_min) && $stable(reg_hr)));

    assert_alarm_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> $past(alarm_en));

    assert_alarm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |=> !alarm_pulse);

    assert_done_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $past(upd_en));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(
    .RUN_CODE (RUN_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_ctl     (osc_ctl),
    .set_mode    (set_mode),
    .bin_mode    (bin_mode),
    .hr24_mode   (hr24_mode),
    .alarm_en    (alarm_en),
    .upd_en      (upd_en),
    .load_stb    (load_stb),
    .reg_sec     (reg_sec),
    .reg_min     (reg_min),
    .reg_hr      (reg_hr),
    .uip         (uip),
    .alarm_pulse (alarm_pulse),
    .upd_done    (upd_done)
);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, dly_tick = 1'b0;
    logic [2:0] osc_ctl = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, hr24_mode = 1'b1;
    logic       alarm_en = 1'b0, upd_en = 1'b1;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic       load_stb = 1'b0;
    logic [7:0] ld_sec = 8'h00, ld_min = 8'h00, ld_hr = 8'h00, ld_dow = 8'h00;
    logic [7:0] ld_dom = 8'h01, ld_mon = 8'h01, ld_yr = 8'h00;
    logic [7:0] reg_sec, reg_min, reg_hr, reg_dow, reg_dom, reg_mon, reg_yr;
    logic       uip, alarm_pulse, upd_done;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr;
    bit  b_bin = 1'b0, b_24 = 1'b1;
    bit  a_seen, d_seen;
    int  hold_sec, hold_hr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_calendar_core dut_i (
        .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick), .dly_tick (dly_tick),
        .osc_ctl (osc_ctl), .set_mode (set_mode), .bin_mode (bin_mode),
        .hr24_mode (hr24_mode), .alarm_en (alarm_en), .upd_en (upd_en),
        .alm_sec (alm_sec), .alm_min (alm_min), .alm_hr (alm_hr),
        .load_stb (load_stb), .ld_sec (ld_sec), .ld_min (ld_min), .ld_hr (ld_hr),
        .ld_dow (ld_dow), .ld_dom (ld_dom), .ld_mon (ld_mon), .ld_yr (ld_yr),
        .reg_sec (reg_sec), .reg_min (reg_min), .reg_hr (reg_hr), .reg_dow (reg_dow),
        .reg_dom (reg_dom), .reg_mon (reg_mon), .reg_yr (reg_yr),
        .uip (uip), .alarm_pulse (alarm_pulse), .upd_done (upd_done)
    );

    function automatic int enc(input int v);
        return b_bin ? v : ((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int enc_hr(input int h);
        int h12;
        if (b_24) return enc(h);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return enc(h12) + ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int mdays(input int mon, input int yr);
        int  full;
        bit  leap;
        full = 2000 + yr;
        leap = ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_vis(input string req);
        chk({req, " sec"}, int'(reg_sec), enc(m_sec));
        chk({req, " min"}, int'(reg_min), enc(m_min));
        chk({req, " hour"}, int'(reg_hr), enc_hr(m_hr));
        chk({req, " dow"}, int'(reg_dow), enc(m_dow));
        chk({req, " dom"}, int'(reg_dom), enc(m_dom));
        chk({req, " mon"}, int'(reg_mon), enc(m_mon));
        chk({req, " yr"}, int'(reg_yr), enc(m_yr));
    endtask

    task automatic set_time(input int h, input int mi, input int s,
                            input int dw, input int d, input int mo, input int y);
        m_hr = h; m_min = mi; m_sec = s; m_dow = dw; m_dom = d; m_mon = mo; m_yr = y;
    endtask

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow + 1) % 7;
                    m_dom++;
                    if (m_dom > mdays(m_mon, m_yr)) begin
                        m_dom = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic load_model(input bit with_tick);
        @(negedge clk);
        ld_sec = 8'(enc(m_sec)); ld_min = 8'(enc(m_min)); ld_hr = 8'(enc_hr(m_hr));
        ld_dow = 8'(enc(m_dow)); ld_dom = 8'(enc(m_dom)); ld_mon = 8'(enc(m_mon));
        ld_yr = 8'(enc(m_yr));
        load_stb = 1'b1; sec_tick = with_tick;
        @(negedge clk);
        load_stb = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic set_modes(input bit bin, input bit h24);
        b_bin = bin; b_24 = h24;
        @(negedge clk);
        bin_mode = bin; hr24_mode = h24;
    endtask

    // one full update cycle; pulses captured into a_seen / d_seen
    task automatic run_second();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        chk("R6 uip rise", int'(uip), 1);
        @(negedge clk);
        dly_tick = 1'b1;
        @(negedge clk); dly_tick = 1'b0;
        chk("R6 uip held", int'(uip), 1);
        @(negedge clk);
        a_seen = alarm_pulse; d_seen = upd_done;
        chk("R6 uip fall", int'(uip), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        set_time(0, 0, 0, 0, 1, 1, 0);
        check_vis("R6 reset");
        chk("R6 reset uip", int'(uip), 0);
        chk("R9 reset done", int'(upd_done), 0);

        // R2 R3 R4 R10: every hour in all four encodings
        for (int md = 0; md < 4; md++) begin
            set_modes(md[0], md[1]);
            for (int h = 0; h < 24; h++) begin
                set_time(h, 59, 59, 6, 15, 6, 7);
                load_model(1'b0);
                check_vis("R10 load");
                run_second();
                model_step();
                check_vis("R3 hour step");
                chk("R9 done", int'(d_seen), 1);
            end
        end

        // R5: month ends over leap and common years
        set_modes(1'b0, 1'b1);
        for (int yi = 0; yi < 5; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int ps = 0; ps < 2; ps++) begin
                    int yv;
                    yv = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 3 : (yi == 3) ? 4 : 99;
                    set_time(23, 59, 59, mo % 7, (ps == 0) ? 28 : mdays(mo, yv), mo, yv);
                    load_model(1'b0);
                    run_second();
                    model_step();
                    check_vis("R5 month end");
                end
            end
        end

        // R4: continuous run through new year in 12-hour BCD and binary
        for (int bm = 0; bm < 2; bm++) begin
            set_modes(bm[0], 1'b0);
            set_time(23, 58, 30, 3, 31, 12, 99);
            load_model(1'b0);
            for (int i = 0; i < 100; i++) begin
                run_second();
                model_step();
                check_vis("R4 run");
            end
        end

        // R1: stopped divider codes ignore the tick
        set_modes(1'b0, 1'b1);
        set_time(8, 30, 10, 2, 5, 3, 21);
        load_model(1'b0);
        for (int code = 0; code < 8; code++) begin
            if (code != 2) begin
                @(negedge clk); osc_ctl = 3'(code); sec_tick = 1'b1;
                @(negedge clk); sec_tick = 1'b0;
                chk("R1 uip", int'(uip), 0);
                dly_tick = 1'b1;
                @(negedge clk); dly_tick = 1'b0;
                @(negedge clk);
                chk("R1 done", int'(upd_done), 0);
                check_vis("R1 held");
            end
        end
        @(negedge clk); osc_ctl = 3'b010;
        run_second();
        model_step();
        check_vis("R1 resume");

        // R7: set flag freezes visible bytes, count keeps running
        hold_sec = enc(m_sec);
        @(negedge clk); set_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
            chk("R7 uip", int'(uip), 0);
            dly_tick = 1'b1;
            @(negedge clk); dly_tick = 1'b0;
            @(negedge clk);
            chk("R7 done", int'(upd_done), 0);
            chk("R7 frozen", int'(reg_sec), hold_sec);
            model_step();
        end
        @(negedge clk); set_mode = 1'b0;
        run_second();
        model_step();
        check_vis("R7 after set");
        // abort inside the update window
        hold_sec = int'(reg_sec);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        chk("R7 window", int'(uip), 1);
        model_step();
        set_mode = 1'b1;
        @(negedge clk);
        chk("R7 abort uip", int'(uip), 0);
        dly_tick = 1'b1;
        @(negedge clk); dly_tick = 1'b0;
        @(negedge clk);
        chk("R7 abort done", int'(upd_done), 0);
        chk("R7 abort regs", int'(reg_sec), hold_sec);
        set_mode = 1'b0;
        run_second();
        model_step();
        check_vis("R7 after abort");

        // R8: alarm matching
        alarm_en = 1'b1;
        set_time(10, 20, 29, 1, 9, 9, 9);
        load_model(1'b0);
        alm_sec = 8'h30; alm_min = 8'h20; alm_hr = 8'h10;
        run_second(); model_step();
        chk("R8 exact match", int'(a_seen), 1);
        @(negedge clk);
        chk("R8 single cycle", int'(alarm_pulse), 0);
        run_second(); model_step();
        chk("R8 mismatch sec", int'(a_seen), 0);
        set_time(4, 7, 59, 1, 9, 9, 9);
        load_model(1'b0);
        alm_sec = 8'h45; alm_min = 8'hC0; alm_hr = 8'hFF;
        for (int i = 0; i < 60; i++) begin
            run_second(); model_step();
            chk("R8 dont care sweep", int'(a_seen), (m_sec == 45) ? 1 : 0);
        end
        alm_sec = 8'hC0; alm_min = 8'h11;
        run_second(); model_step();
        chk("R8 minute mismatch", int'(a_seen), 0);
        set_modes(1'b0, 1'b0);
        set_time(13, 5, 59, 1, 9, 9, 9);
        load_model(1'b0);
        alm_hr = 8'h81; alm_min = 8'h06; alm_sec = 8'h00;
        run_second(); model_step();
        chk("R8 pm hour match", int'(a_seen), 1);
        alarm_en = 1'b0; alm_hr = 8'hFF; alm_min = 8'hFF; alm_sec = 8'hFF;
        run_second(); model_step();
        chk("R8 disabled", int'(a_seen), 0);

        // R9: update-ended enable
        upd_en = 1'b0;
        run_second(); model_step();
        chk("R9 off", int'(d_seen), 0);
        upd_en = 1'b1;
        run_second(); model_step();
        chk("R9 on", int'(d_seen), 1);

        // R10: 12 AM / 12 PM loads and tick ignored alongside load
        set_time(0, 59, 59, 2, 3, 4, 5);
        load_model(1'b0);
        chk("R10 12am byte", int'(reg_hr), 8'h12);
        run_second(); model_step();
        chk("R10 12am step", int'(reg_hr), 8'h01);
        set_time(12, 59, 59, 2, 3, 4, 5);
        load_model(1'b0);
        chk("R10 12pm byte", int'(reg_hr), 8'h92);
        run_second(); model_step();
        chk("R10 12pm step", int'(reg_hr), 8'h81);
        set_time(6, 6, 6, 2, 3, 4, 5);
        load_model(1'b1);
        chk("R10 tick ignored uip", int'(uip), 0);
        check_vis("R10 tick ignored");
        run_second(); model_step();
        check_vis("R10 after load");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule